// File: doc/BRIEF.md
# Early-Terminating Serial ADC Readout Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a serial output. It drives the converter's active-low chip-select and its serial clock, and it takes in one result bit per serial clock, most significant bit first. The controller can end a conversion early in two ways. The first is a programmed bit limit. The second is a window test: it stops as soon as the bits already received prove that the sample lies below a low bound or above a high bound. After either kind of stop it releases chip-select at once. The converter then powers down fully, and the next sample can start sooner.

A trigger pulse starts a conversion. The trigger can come from a start request or from a periodic timer elsewhere on the chip. At the trigger, the controller latches the clock divider, the bit limit and the window settings, so these inputs may change during a conversion without effect. At the end of each conversion the controller reports three things: the bits it received, left-aligned with zeros below them; the number of bits it received; and a flag that says whether the window test proved the sample out of range. A one-cycle strobe marks each new result.

Top module: `adc_shortcycle_rd`

## Requirements
- R1: After reset, `cs_n_o` is 1 and `sclk_o` is 0. `valid_o`, `out_win_o`, `result_o` and `nbits_o` are all 0.
- R2: A `trig_i` seen while idle pulls `cs_n_o` low in the next cycle. It also latches `div_i`, `bit_lim_i`, `win_en_i`, `win_lo_i` and `win_hi_i`. Changes to these inputs after the trigger do not affect that conversion.
- R3: While `cs_n_o` is low, each low phase and each high phase of `sclk_o` lasts exactly `div+1` system clock cycles, where div is the latched divider. `sclk_o` is 0 whenever `cs_n_o` is 1.
- R4: `sdata_i` is sampled on the system clock edge at which `sclk_o` goes from 0 to 1. Exactly one bit is taken per rising edge. The first bit taken is the result's most significant bit.
- R5: The conversion ends after L bits, where L is the latched bit limit. A limit of 0, or any value above 16, means L = 16.
- R6: With the window enabled, the controller forms two values after each bit. The first is the received prefix with all unreceived bits set to 0. The second is the same prefix with all unreceived bits set to 1. The conversion ends at the first bit where the ones-filled value is below `win_lo_i`, or where the zeros-filled value is above `win_hi_i`.
- R7: The conversion ends at the end of the last bit's high phase. In that cycle `sclk_o` falls and `cs_n_o` rises together. The number of `sclk_o` rising edges during the conversion equals `nbits_o`.
- R8: `result_o` holds the received bits in its top `nbits_o` positions, with zeros below them. `nbits_o` gives the count. Both values hold until the next conversion completes.
- R9: `valid_o` pulses for exactly one cycle: the first cycle in which `cs_n_o` is high again.
- R10: A `trig_i` pulse during a conversion is ignored. It produces no extra result and does not change the running conversion.
- R11: `out_win_o` is 1 only when the window is enabled and the R6 test proved the sample out of range. If the conversion stops at the bit limit without such proof, or the window is disabled, `out_win_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start-conversion pulse |
| div_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| bit_lim_i | input | CNT_W | Number of bits to take (0 or more than 16 means 16) |
| win_en_i | input | 1 | Enables early stop on the window test |
| win_lo_i | input | RES_W | Lower window bound (inclusive) |
| win_hi_i | input | RES_W | Upper window bound (inclusive) |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Converter chip-select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| result_o | output | RES_W | Received bits, left-aligned, with zeros below |
| valid_o | output | 1 | One-cycle strobe for a new result |
| out_win_o | output | 1 | Sample proven outside the window |
| nbits_o | output | CNT_W | Number of bits received |

## Verification
The assertions assume that the latched divider, limit and window bounds stay fixed from the trigger until `valid_o`. They also assume the converter changes `sdata_i` only after a falling edge of `sclk_o`, so the bit is stable at the rising edge that samples it. The bench's converter model shifts its word only on a falling edge of `sclk_o` and reloads it whenever `cs_n_o` is high. The bench also sets `win_lo_i` no higher than `win_hi_i`. Stimulus changes the configuration inputs and sends extra triggers only in the middle of a conversion. This exercises the latching and trigger-ignore behaviour while staying inside those assumptions.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned ADC_BITS = 16;
  localparam int unsigned ADC_DIV_W = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rd_state_e;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             edge_due;

  assign edge_due = run_i && (cnt_q == half_i);
  assign rise_o   = edge_due && !sclk_q;
  assign fall_o   = edge_due && sclk_q;
  assign sclk_o   = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (edge_due) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end

  // R3: the serial clock level only moves on a divider terminal count
  a_r3_steady_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !edge_due) |=> $stable(sclk_q));
endmodule

// File: rtl/adc_bit_capture.sv
module adc_bit_capture #(
  parameter int RES_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic             bit_i,
  output logic [RES_W-1:0] prefix_o,
  output logic [CNT_W-1:0] count_o
);
  logic [RES_W-1:0] bits_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (take_i) begin
      bits_q <= {bits_q[RES_W-2:0], bit_i};
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign prefix_o = bits_q;
  assign count_o  = cnt_q;
endmodule

// File: rtl/adc_window_judge.sv
module adc_window_judge #(
  parameter int RES_W = 16,
  parameter int CNT_W = 5
) (
  input  logic [RES_W-1:0] prefix_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [RES_W-1:0] lo_i,
  input  logic [RES_W-1:0] hi_i,
  output logic [RES_W-1:0] zero_fill_o,
  output logic [RES_W-1:0] one_fill_o,
  output logic             below_o,
  output logic             above_o
);
  // right-aligned prefix moved to the top, unreceived bits zero
  function automatic logic [RES_W-1:0] zero_pad(input logic [RES_W-1:0] p,
                                                input logic [CNT_W-1:0] n);
    return p << (RES_W - int'(n));
  endfunction

  // mask covering the bits not yet received
  function automatic logic [RES_W-1:0] tail_mask(input logic [CNT_W-1:0] n);
    return {RES_W{1'b1}} >> n;
  endfunction

  assign zero_fill_o = zero_pad(prefix_i, count_i);
  assign one_fill_o  = zero_fill_o | tail_mask(count_i);
  assign below_o     = one_fill_o < lo_i;
  assign above_o     = zero_fill_o > hi_i;
endmodule

// File: rtl/adc_shortcycle_rd.sv
module adc_shortcycle_rd
  import adc_rd_pkg::*;
#(
  parameter int RES_W = ADC_BITS,
  parameter int DIV_W = ADC_DIV_W,
  parameter int CNT_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CNT_W-1:0] bit_lim_i,
  input  logic             win_en_i,
  input  logic [RES_W-1:0] win_lo_i,
  input  logic [RES_W-1:0] win_hi_i,
  input  logic             sdata_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             out_win_o,
  output logic [CNT_W-1:0] nbits_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(RES_W);

  function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] n);
    if (n == '0 || int'(n) > RES_W) return FULL_CNT;
    return n;
  endfunction

  rd_state_e        state_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] lim_q;
  logic             win_en_q;
  logic [RES_W-1:0] lo_q, hi_q;
  logic             cs_n_q, valid_q, out_q;
  logic [RES_W-1:0] result_q;
  logic [CNT_W-1:0] nbits_q;

  // named internal events
  logic             start_ev, rise_ev, fall_ev, stop_ev, proven_out, limit_hit;
  logic [RES_W-1:0] cap_bits, zero_fill, one_fill;
  logic [CNT_W-1:0] cap_cnt;
  logic             below, above;

  assign start_ev = (state_q == ST_IDLE) && trig_i;

  adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_RUN), .half_i(div_q),
    .sclk_o(sclk_o), .rise_o(rise_ev), .fall_o(fall_ev)
  );

  adc_bit_capture #(.RES_W(RES_W), .CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear_i(start_ev), .take_i(rise_ev),
    .bit_i(sdata_i), .prefix_o(cap_bits), .count_o(cap_cnt)
  );

  adc_window_judge #(.RES_W(RES_W), .CNT_W(CNT_W)) u_win (
    .prefix_i(cap_bits), .count_i(cap_cnt), .lo_i(lo_q), .hi_i(hi_q),
    .zero_fill_o(zero_fill), .one_fill_o(one_fill),
    .below_o(below), .above_o(above)
  );

  assign proven_out = win_en_q && (below || above);
  assign limit_hit  = (cap_cnt == lim_q);
  assign stop_ev    = fall_ev && (limit_hit || proven_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      div_q    <= '0;
      lim_q    <= FULL_CNT;
      win_en_q <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      cs_n_q   <= 1'b1;
      valid_q  <= 1'b0;
      out_q    <= 1'b0;
      result_q <= '0;
      nbits_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (start_ev) begin
        state_q  <= ST_RUN;
        cs_n_q   <= 1'b0;
        div_q    <= div_i;
        lim_q    <= eff_limit(bit_lim_i);
        win_en_q <= win_en_i;
        lo_q     <= win_lo_i;
        hi_q     <= win_hi_i;
      end else if (stop_ev) begin
        state_q  <= ST_IDLE;
        cs_n_q   <= 1'b1;
        valid_q  <= 1'b1;
        result_q <= zero_fill;
        nbits_q  <= cap_cnt;
        out_q    <= proven_out;
      end
    end
  end

  assign cs_n_o    = cs_n_q;
  assign valid_o   = valid_q;
  assign result_o  = result_q;
  assign nbits_o   = nbits_q;
  assign out_win_o = out_q;

  // R2: an idle trigger selects the converter on the next cycle
  a_r2_select_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !cs_n_o);
  // R3: clock parked low while deselected
  a_r3_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
  // R4: each rising serial edge adds exactly one bit
  a_r4_bit_per_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> cap_cnt == $past(cap_cnt) + CNT_W'(1));
  // R5: never more bits than the latched limit
  a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> cap_cnt <= lim_q);
  // R7: a conversion ends with one bit taken at least
  a_r7_nonzero_count: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> nbits_o != '0);
  // R8: bits below the received count are zero
  a_r8_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (result_o & ({RES_W{1'b1}} >> nbits_o)) == '0);
  // R9: strobe coincides with chip-select release
  a_r9_strobe_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> valid_o);
  a_r9_release_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $rose(cs_n_o));
  // R10: a trigger during a conversion leaves it running unchanged
  a_r10_busy_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && trig_i && !stop_ev) |=> (!cs_n_o && $stable(lim_q)));
  // R11: out flag only with the window enabled
  a_r11_flag_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && out_win_o) |-> win_en_q);
endmodule

// File: tb/test_adc_shortcycle_rd.sv
module test_adc_shortcycle_rd;
  localparam int RES_W = 16;
  localparam int DIV_W = 8;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             trig_i = 1'b0;
  logic [DIV_W-1:0] div_i = '0;
  logic [CNT_W-1:0] bit_lim_i = '0;
  logic             win_en_i = 1'b0;
  logic [RES_W-1:0] win_lo_i = '0;
  logic [RES_W-1:0] win_hi_i = '1;
  logic             sdata_i;
  logic             cs_n_o, sclk_o, valid_o, out_win_o;
  logic [RES_W-1:0] result_o;
  logic [CNT_W-1:0] nbits_o;

  always #4 clk = ~clk;

  adc_shortcycle_rd i_adc_shortcycle_rd (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .div_i(div_i),
    .bit_lim_i(bit_lim_i), .win_en_i(win_en_i), .win_lo_i(win_lo_i),
    .win_hi_i(win_hi_i), .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .result_o(result_o), .valid_o(valid_o), .out_win_o(out_win_o),
    .nbits_o(nbits_o)
  );

  // converter model: bit index advances on each falling serial edge
  logic [RES_W-1:0] adc_word = '0;
  int               bit_idx = 0;
  always @(negedge sclk_o or posedge cs_n_o) begin
    if (cs_n_o) bit_idx <= 0;
    else        bit_idx <= bit_idx + 1;
  end
  assign sdata_i = (bit_idx < RES_W) ? adc_word[RES_W-1-bit_idx] : 1'b0;

  typedef struct packed {
    logic [RES_W-1:0] res;
    logic [CNT_W-1:0] n;
    logic             o;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;
  int   vectors = 0;
  int   fails = 0;
  int   cur_div = 0;
  bit   finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model written from R5, R6 and R11
  function automatic exp_t predict(input logic [RES_W-1:0] w, input int lim,
                                   input bit en, input int lo, input int hi);
    exp_t e;
    int   stop_at;
    stop_at = (lim == 0 || lim > RES_W) ? RES_W : lim;
    e.o = 1'b0;
    e.n = CNT_W'(stop_at);
    for (int k = 1; k <= RES_W; k++) begin
      int zf, of;
      zf = int'(w) & ~((1 << (RES_W - k)) - 1) & 16'hFFFF;
      of = zf | ((1 << (RES_W - k)) - 1);
      if (en && (of < lo || zf > hi)) begin
        e.o = 1'b1;
        e.n = CNT_W'(k);
        break;
      end
      if (k == stop_at) break;
    end
    e.res = w & ~(16'hFFFF >> e.n);
    return e;
  endfunction

  task automatic run_conv(input logic [RES_W-1:0] w, input int dv, input int lim,
                          input bit en, input int lo, input int hi,
                          input bit disturb);
    exp_t e;
    @(negedge clk);
    adc_word  = w;
    div_i     = DIV_W'(dv);
    bit_lim_i = CNT_W'(lim);
    win_en_i  = en;
    win_lo_i  = RES_W'(lo);
    win_hi_i  = RES_W'(hi);
    e = predict(w, lim, en, lo, hi);
    q.push_back(e);
    last_exp = e;
    cur_div  = dv;
    trig_i   = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    check(cs_n_o == 1'b0, "R2 select after trigger", cs_n_o, 0);
    if (disturb) begin
      // R2 latching and R10 ignored trigger
      div_i     = DIV_W'(dv + 2);
      bit_lim_i = CNT_W'(16);
      win_en_i  = ~en;
      repeat (5) @(negedge clk);
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
    end
    while (!cs_n_o) @(negedge clk);
    repeat (6) @(negedge clk);
    check(result_o == last_exp.res, "R8 result held", result_o, last_exp.res);
    check(valid_o == 1'b0, "R9 strobe single cycle", valid_o, 0);
  endtask

  // monitor: scoreboard pop, phase length and edge count
  logic prev_s = 1'b0;
  bit   prev_low = 1'b0;
  int   plen = 0;
  int   rises = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n_o) begin
        if (prev_low && sclk_o == prev_s) plen++;
        else begin
          if (prev_low) check(plen == cur_div + 1, "R3 phase length", plen, cur_div + 1);
          plen = 1;
        end
        if (sclk_o && !prev_s) rises++;
      end else if (prev_low) begin
        check(plen == cur_div + 1, "R3 last phase length", plen, cur_div + 1);
        check(sclk_o == 1'b0, "R7 clock falls with release", sclk_o, 0);
      end
      if (valid_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R10 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(result_o == e.res, "R4 R8 result bits", result_o, e.res);
          check(nbits_o == e.n, "R5 R6 bit count", nbits_o, e.n);
          check(out_win_o == e.o, "R6 R11 window flag", out_win_o, e.o);
          check(rises == int'(e.n), "R7 edges equal count", rises, e.n);
        end
        rises = 0;
      end
      prev_s   = sclk_o;
      prev_low = !cs_n_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n_o == 1'b1, "R1 cs_n reset", cs_n_o, 1);
    check(sclk_o == 1'b0, "R1 sclk reset", sclk_o, 0);
    check(valid_o == 1'b0, "R1 valid reset", valid_o, 0);
    check(result_o == '0 && nbits_o == '0 && out_win_o == 1'b0,
          "R1 result reset", result_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_conv(16'hA5C3, 0, 16, 0, 0, 16'hFFFF, 0);   // R4 full word
    run_conv(16'h1237, 2, 14, 0, 0, 16'hFFFF, 0);   // R5 limit 14
    run_conv(16'h8001, 1, 0, 0, 0, 16'hFFFF, 0);    // R5 zero means full
    run_conv(16'h7FFE, 0, 20, 0, 0, 16'hFFFF, 0);   // R5 above range means full
    run_conv(16'hFFFF, 3, 1, 0, 0, 16'hFFFF, 0);    // R5 single bit
    run_conv(16'hF123, 1, 16, 1, 16'h4000, 16'hC000, 0); // R6 above early
    run_conv(16'h0123, 0, 16, 1, 16'h4000, 16'hC000, 0); // R6 below early
    run_conv(16'h8000, 0, 16, 1, 16'h4000, 16'hC000, 0); // R11 inside
    run_conv(16'hC001, 0, 16, 1, 16'h4000, 16'hC000, 0); // R6 last-bit decision
    run_conv(16'hF000, 0, 2, 1, 16'h4000, 16'hC000, 0);  // R11 limit before proof
    run_conv(16'h3C3C, 1, 5, 0, 0, 16'hFFFF, 1);    // R2 R10 latch and busy trigger
    for (int i = 0; i < 20; i++) begin
      int lo, hi;
      lo = $urandom_range(0, 16'h7FFF);
      hi = $urandom_range(lo, 16'hFFFF);
      run_conv(RES_W'($urandom), $urandom_range(0, 3), $urandom_range(0, 18),
               1'($urandom), lo, hi, 0);
    end
    check(q.size() == 0, "R10 no pending results", q.size(), 0);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule